// File: doc/BRIEF.md
# Reset Cause and Software Reset Request Register

This block keeps a small record of why the system last came out of reset. It also lets software ask for a new system reset, either as a full power-on reset or as a lighter externally initiated one. Software reaches it through a 32-bit register port. The block decodes an eight-byte window whose upper word holds the record. It drives two outputs: a single-cycle system reset request, and a level that tells the reset controller whether the next reset it carries out should count as a power-on reset.

The surrounding reset logic reports back in two ways. A hardware power-on indication reloads the record unconditionally. A reset-completed event reloads it only if software asked for a power-on reset; after any other reset the record keeps what it held. Status bits are cleared by writing one to them. The two software request bits are set by writing one and cannot be cleared by writing zero.

Top module: `rcc_reset_cause`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads status 0x8000_0000, holds `sys_rst_req` low and holds `next_por` low.
- R2: `acc_rdata` returns the status word when `acc_addr` is 0xF024 to 0xF027 (window base 0xF020, byte-offset bit 2 set). Status bits 26:0 always read as zero. Addresses 0xF020 to 0xF023, and any address outside the window, read as zero.
- R3: A data-word write clears each of status bits 31, 28 and 27 where the written value has a one, and leaves them unchanged where it has a zero.
- R4: A data-word write sets status bit 30 or bit 29 where the written value has a one. Writing zero to these bits leaves them unchanged.
- R5: A data-word write with bit 30 set raises `sys_rst_req` in the cycle after the write and sets `next_por` to 1.
- R6: A data-word write with bit 29 set and bit 30 clear raises `sys_rst_req` in the cycle after the write and leaves `next_por` unchanged.
- R7: `sys_rst_req` is high for exactly one cycle per requesting write. It is never high unless the previous cycle held an accepted requesting write.
- R8: A `rst_done` pulse while `next_por` is 1 loads status 0x8000_0000 and clears `next_por`.
- R9: A `rst_done` pulse while `next_por` is 0 leaves the status word unchanged.
- R10: `pwr_on` high at a clock edge loads status 0x8000_0000 and clears `next_por` and `sys_rst_req`. It overrides a `rst_done` pulse or a write in the same cycle.
- R11: Writes to 0xF020 to 0xF023, writes outside the window, and written bits 26:0 have no effect on status, `next_por` or `sys_rst_req`.
- R12: A write in the same cycle as a `rst_done` pulse is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 16 | Byte address of the register access |
| acc_wr | input | 1 | Write strobe, one cycle per write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from `acc_addr` |
| pwr_on | input | 1 | Hardware power-on indication |
| rst_done | input | 1 | Pulse when a system reset has completed |
| sys_rst_req | output | 1 | One-cycle system reset request |
| next_por | output | 1 | Next reset is to be treated as power-on |

## Verification
A corrupted status bit is visible on `acc_rdata` in the same cycle the data word is addressed. The bench reads the data word on most cycles so that such an error is caught within a cycle of its cause. A wrong pending power-on flag shows at once on `next_por`. It also shows one reset later, when `rst_done` either reloads or fails to reload the status word. A faulty request path shows as a missing, doubled or spurious `sys_rst_req` pulse in the cycle after the write, and a cycle-accurate model compares all three outputs on every clock.

// File: rtl/rcc_pkg.sv
// Package: shared bit positions and masks of the reset cause word.
// Assumes a 32-bit data word; other packages are not needed.
package rcc_pkg;
    localparam int STAT_W     = 32;
    localparam int B_HW_POR   = 31;
    localparam int B_SW_POR   = 30;
    localparam int B_SW_EXT   = 29;
    localparam int B_BTN_POR  = 28;
    localparam int B_BTN_EXT  = 27;

    localparam logic [STAT_W-1:0] M_ONE     = {{(STAT_W-1){1'b0}}, 1'b1};
    localparam logic [STAT_W-1:0] M_W1C     = (M_ONE << B_HW_POR) | (M_ONE << B_BTN_POR)
                                            | (M_ONE << B_BTN_EXT);
    localparam logic [STAT_W-1:0] M_W1S     = (M_ONE << B_SW_POR) | (M_ONE << B_SW_EXT);
    localparam logic [STAT_W-1:0] M_LIVE    = M_W1C | M_W1S;
    localparam logic [STAT_W-1:0] POR_VALUE = M_ONE << B_HW_POR;
endpackage

// File: rtl/rcc_decode.sv
// Module: address decode of the eight-byte register window.
// Assumes WIN_BASE is aligned to eight bytes; only the upper word
// (byte-offset bit 2 set) is backed by storage.
module rcc_decode #(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF020
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              data_sel,
    output logic              wr_hit
);
    localparam int WIN_LSB = 3;

    // Select the data word: window match plus offset bit 2.
    always_comb begin
        data_sel = (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]) && addr[2];
        wr_hit   = wr && data_sel;
    end
endmodule

// File: rtl/rcc_state.sv
// Module: reset cause storage, pending power-on flag and request pulse.
// Assumes wr_hit already qualifies the data-word write. Priority per cycle:
// pwr_on, then rst_done, then the software write.
module rcc_state
    import rcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              rst_done,
    input  logic              wr_hit,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] status,
    output logic              pend_por,
    output logic              req
);
    logic [STAT_W-1:0] wv;
    logic [STAT_W-1:0] st_wr;
    logic              take_wr;

    // Mask the write value and form the post-write status.
    always_comb begin
        wv      = wdata & M_LIVE;
        st_wr   = (status & ~(wv & M_W1C)) | (wv & M_W1S);
        take_wr = wr_hit && !pwr_on && !rst_done;
    end

    // Update status, pending flag and request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_on) begin
            status   <= POR_VALUE;
            pend_por <= 1'b0;
            req      <= 1'b0;
        end else begin
            req <= take_wr && (wv[B_SW_POR] || wv[B_SW_EXT]);
            if (rst_done) begin
                if (pend_por) begin
                    status   <= POR_VALUE;
                    pend_por <= 1'b0;
                end
            end else if (take_wr) begin
                status <= st_wr;
                if (wv[B_SW_POR]) pend_por <= 1'b1;
            end
        end
    end

    AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(wr_hit && (wdata[B_SW_POR] || wdata[B_SW_EXT]) && !pwr_on && !rst_done)); // R7
    AST_PWRON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_on) |-> (status == POR_VALUE && !pend_por && !req)); // R10
    AST_SWPOR_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_hit && wdata[B_SW_POR] && !pwr_on && !rst_done)) |-> (pend_por && req)); // R5
    AST_WARM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_done && !pend_por && !pwr_on)) |-> $stable(status)); // R9
    AST_DEAD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~M_LIVE) == '0); // R2
endmodule

// File: rtl/rcc_reset_cause.sv
// Module: top of the reset cause register with software reset requests.
// Assumes a single-cycle write strobe and a combinational read path;
// the chip-level bus decodes writes into acc_wr pulses.
module rcc_reset_cause
    import rcc_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic              pwr_on,
    input  logic              rst_done,
    output logic              sys_rst_req,
    output logic              next_por
);
    logic              data_sel;
    logic              wr_hit;
    logic [STAT_W-1:0] status;

    rcc_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
        .addr     (acc_addr),
        .wr       (acc_wr),
        .data_sel (data_sel),
        .wr_hit   (wr_hit)
    );

    rcc_state u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_on   (pwr_on),
        .rst_done (rst_done),
        .wr_hit   (wr_hit),
        .wdata    (acc_wdata),
        .status   (status),
        .pend_por (next_por),
        .req      (sys_rst_req)
    );

    // Return the status only for the data word.
    always_comb acc_rdata = data_sel ? status : '0;

    AST_IDLE_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !data_sel |-> acc_rdata == '0); // R2
endmodule

// File: tb/sim_rcc_reset_cause.sv
// Bench: behavioural model of the reset cause register, compared on every clock.
module sim_rcc_reset_cause;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] acc_addr = 16'h0000;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_wdata = 32'h0;
    logic [31:0] acc_rdata;
    logic        pwr_on = 1'b0;
    logic        rst_done = 1'b0;
    logic        sys_rst_req;
    logic        next_por;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R1";

    logic [31:0] m_stat = 32'h8000_0000;
    logic        m_pend = 1'b0;
    logic        m_req  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcc_reset_cause u0 (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .pwr_on(pwr_on),
        .rst_done(rst_done), .sys_rst_req(sys_rst_req), .next_por(next_por)
    );

    function automatic bit is_data(input logic [15:0] a);
        return (a >= 16'hF024) && (a <= 16'hF027);
    endfunction

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        logic [31:0] v;
        if (!rst_n || pwr_on) begin
            m_stat <= 32'h8000_0000; m_pend <= 1'b0; m_req <= 1'b0;
        end else begin
            m_req <= 1'b0;
            if (rst_done) begin
                if (m_pend) begin m_stat <= 32'h8000_0000; m_pend <= 1'b0; end
            end else if (acc_wr && is_data(acc_addr)) begin
                v = acc_wdata;
                m_stat <= (m_stat & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
                if (v[30]) begin m_req <= 1'b1; m_pend <= 1'b1; end
                else if (v[29]) m_req <= 1'b1;
            end
        end
    end

    // Compare every output on every falling edge.
    always @(negedge clk) begin
        logic [33:0] act, exp;
        if (started && !finished) begin
            act = {acc_rdata, sys_rst_req, next_por};
            exp = {(is_data(acc_addr) ? m_stat : 32'h0), m_req, m_pend};
            checks++;
            if (act !== exp) begin
                fails++;
                $display("FAIL %s: rdata/req/por actual %h/%b/%b expected %h/%b/%b",
                         cur_req, act[33:2], act[1], act[0], exp[33:2], exp[1], exp[0]);
            end
        end
    end

    task automatic cyc(input logic [15:0] a, input logic w, input logic [31:0] d,
                       input logic po, input logic rd);
        @(negedge clk); #1;
        acc_addr = a; acc_wr = w; acc_wdata = d; pwr_on = po; rst_done = rd;
    endtask

    task automatic rd_data(input int n);
        for (int i = 0; i < n; i++) cyc(16'hF024, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        cyc(16'hF024, 1'b0, 32'h0, 1'b0, 1'b0);
        started = 1'b1;
        rd_data(3);
        rst_n = 1'b1;
        cur_req = "R2"; rd_data(2);
        cyc(16'hF020, 1'b0, 32'h0, 1'b0, 1'b0);
        cyc(16'hF027, 1'b0, 32'h0, 1'b0, 1'b0);
        cyc(16'h1024, 1'b0, 32'h0, 1'b0, 1'b0);
        cyc(16'hF02C, 1'b0, 32'h0, 1'b0, 1'b0);
        cur_req = "R11";
        cyc(16'hF020, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0); rd_data(2);
        cyc(16'h1024, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0); rd_data(2);
        cyc(16'hF024, 1'b1, 32'h07FF_FFFF, 1'b0, 1'b0); rd_data(2);
        cur_req = "R3";
        cyc(16'hF024, 1'b1, 32'h8000_0000, 1'b0, 1'b0); rd_data(2);
        cur_req = "R6";
        cyc(16'hF026, 1'b1, 32'h2000_0000, 1'b0, 1'b0);
        cur_req = "R7"; rd_data(4);
        cur_req = "R4";
        cyc(16'hF024, 1'b1, 32'h0000_0000, 1'b0, 1'b0); rd_data(2);
        cur_req = "R9";
        cyc(16'hF024, 1'b0, 32'h0, 1'b0, 1'b1); rd_data(2);
        cur_req = "R5";
        cyc(16'hF024, 1'b1, 32'h4000_0000, 1'b0, 1'b0);
        cur_req = "R7"; rd_data(3);
        cur_req = "R8";
        cyc(16'hF024, 1'b0, 32'h0, 1'b0, 1'b1); rd_data(2);
        cur_req = "R12";
        cyc(16'hF024, 1'b1, 32'h6000_0000, 1'b0, 1'b1); rd_data(3);
        cur_req = "R10";
        cyc(16'hF024, 1'b1, 32'h4000_0000, 1'b0, 1'b0);
        cyc(16'hF024, 1'b1, 32'h2000_0000, 1'b1, 1'b0); rd_data(2);
        cyc(16'hF024, 1'b1, 32'h6000_0000, 1'b0, 1'b0);
        cyc(16'hF024, 1'b0, 32'h0, 1'b1, 1'b1); rd_data(2);
        cur_req = "R7";
        cyc(16'hF024, 1'b1, 32'h2000_0000, 1'b0, 1'b0);
        cyc(16'hF024, 1'b1, 32'h2000_0000, 1'b0, 1'b0); rd_data(3);
        cur_req = "R3";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [15:0] a;
            r = $urandom;
            a = 16'hF020 + 16'(r[2:0]);
            if (r[3]) a = 16'h0F24;
            cyc(a, r[4] & r[5], $urandom, (r[12:6] == 7'd0), r[13] & r[14] & r[15]);
        end
        cur_req = "R1";
        cyc(16'hF024, 1'b0, 32'h0, 1'b0, 1'b0);
        rst_n = 1'b0; rd_data(2);
        rst_n = 1'b1; rd_data(2);
        @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule